// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device side of a small serial EEPROM that a host reaches over three wires: a chip select, a shift clock and a serial data input, plus a serial data output with its own drive enable. The pins are sampled into a faster system clock through two-flop synchronizers. Edges of the shift clock and chip select are found from those samples, so the whole block runs on one clock. Each instruction opens with a rising chip select. A start bit of 1 follows, then a two-bit opcode, then an address whose width depends on the word size picked by the organization input.

The array is a register file of bytes. In 16-bit mode one word covers an aligned pair of bytes. A programming-enable latch guards every operation that changes the array. Each accepted change starts a self-timed program cycle whose length is set by a parameter in system clock cycles. During that cycle the block accepts no instruction. A host can poll it by dropping and raising chip select, and the data output then shows busy (0) and later ready (1).

Top module: `ser_eeprom_slave`

## Requirements
- R1: An instruction is decoded only after a rising chip select. Zeros on the data input before the first 1 are skipped. That 1 is the start bit and is followed by a 2-bit opcode and the address, all MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 special.
- R2: With `wide_i` = 1, words are 16 bits and the address is 6 bits. With `wide_i` = 0, words are 8 bits and the address is 7 bits. A 16-bit word at address a holds byte 2a in its upper half and byte 2a+1 in its lower half.
- R3: The read is complete once the last address bit is taken. The output is then driven with one 0 bit, and each later rising shift-clock edge presents the next data bit, MSB first.
- R4: After reset, programming is disabled. A special opcode whose two upper address bits are 11 enables it, and 00 disables it. The latch keeps its value until changed or reset. While disabled, write, erase, erase-all and write-all leave the array unchanged. Read works in either state.
- R5: Write stores the shifted data word at the address. Erase sets every bit of the addressed word to 1.
- R6: The special opcode with upper address bits 10 sets every array bit to 1. With upper address bits 01, one data word is shifted in and then stored in every location.
- R7: An accepted change starts a busy period of PROG_CYCLES clocks. The period starts at the last data bit (write, write-all) or at the last address bit (erase, erase-all). Any instruction sent during it is ignored.
- R8: Chip select can rise during a busy period. From then until chip select falls, the output is driven: 0 while busy, 1 once ready. A rise after the period has ended shows no status.
- R9: The output enable is low after reset and within 3 clocks of chip select going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Shift clock from the host |
| sdi_i | input | 1 | Serial data input |
| wide_i | input | 1 | Word organization: 1 = 16-bit, 0 = 8-bit |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for the serial output |

## Verification
The hardest state to reach is an instruction that arrives while a program cycle is still counting. That instruction must be rejected, and the status bit must switch from 0 to 1 while chip select stays high. To get there, the stimulus toggles chip select straight after the last data bit of a write. It then shifts a second full write to the same address into the status window, waits out the cycle with chip select still high, and reads the address back to confirm the first value survived. A second directed case polls just before the cycle ends and again just after it, to pin down the busy window's length.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_STAT,
    ST_HOLD
  } st_e;

  typedef enum logic [1:0] {
    MOP_NONE,
    MOP_WORD,
    MOP_ALL
  } mop_e;
endpackage

// File: rtl/ser_eeprom_sync.sv
module ser_eeprom_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/ser_eeprom_array.sv
module ser_eeprom_array
  import ser_eeprom_pkg::*;
#(
  parameter int ABITS = 7
) (
  input  logic             clk,
  input  logic             wide_i,
  input  logic [ABITS-1:0] addr_i,
  input  mop_e             op_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o
);
  localparam int DEPTH = 1 << ABITS;

  logic [7:0]       mem   [DEPTH];
  logic [7:0]       val   [DEPTH];
  logic [DEPTH-1:0] en;

  // Per-byte enable and value; upper byte of a wide word sits at even index
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [ABITS-1:0] IDX = ABITS'(g);
    logic hit;
    assign hit    = wide_i ? (addr_i[ABITS-1:1] == IDX[ABITS-1:1]) : (addr_i == IDX);
    assign en[g]  = (op_i == MOP_ALL) || ((op_i == MOP_WORD) && hit);
    assign val[g] = (wide_i && !IDX[0]) ? wdata_i[15:8] : wdata_i[7:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (en[i]) mem[i] <= val[i];
    end
  end

  assign rdata_o = wide_i ? {mem[{addr_i[ABITS-1:1], 1'b0}], mem[{addr_i[ABITS-1:1], 1'b1}]}
                          : {8'h00, mem[addr_i]};
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import ser_eeprom_pkg::*;
#(
  parameter int ABITS       = 7,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic wide_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int HBITS = ABITS + 2;
  localparam int BW    = $clog2(HBITS + 17);
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [BW-1:0] HLAST_N = BW'(HBITS - 1);
  localparam logic [BW-1:0] HLAST_W = BW'(HBITS - 2);
  localparam logic [BW-1:0] DLAST_N = BW'(7);
  localparam logic [BW-1:0] DLAST_W = BW'(15);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic [2:0] pin_s;
  logic cs_s, sk_s, di_s, cs_q, sk_q, cs_rise, sk_rise;

  ser_eeprom_sync #(.W(3)) sync_i (
    .clk    (clk),
    .rst_ni (rst_i_n),
    .d_i    ({sel_i, sclk_i, sdi_i}),
    .q_o    (pin_s)
  );
  assign {cs_s, sk_s, di_s} = pin_s;
  assign cs_rise = cs_s & ~cs_q;
  assign sk_rise = sk_s & ~sk_q;

  st_e              state_q, state_d;
  logic [BW-1:0]    cnt_q, cnt_d;
  logic [HBITS-2:0] hdr_q, hdr_d;
  logic [14:0]      dat_q, dat_d;
  logic [15:0]      rd_q, rd_d;
  logic [ABITS-1:0] addr_q, addr_d;
  logic [CW-1:0]    bcnt_q, bcnt_d;
  logic             prog_en_q, prog_en_d, busy_q, busy_d, sdo_q, sdo_d, all_q, all_d;

  logic [HBITS-1:0] hdr_nx;
  logic [15:0]      dat_nx, mem_wd, rdata;
  logic [1:0]       opc, sub;
  logic [ABITS-1:0] dec_addr, arr_addr;
  mop_e             mem_op;

  assign hdr_nx   = {hdr_q, di_s};
  assign dat_nx   = {dat_q, di_s};
  assign opc      = wide_i ? hdr_nx[HBITS-2:HBITS-3] : hdr_nx[HBITS-1:HBITS-2];
  assign sub      = wide_i ? hdr_nx[ABITS-2:ABITS-3] : hdr_nx[ABITS-1:ABITS-2];
  assign dec_addr = wide_i ? {hdr_nx[ABITS-2:0], 1'b0} : hdr_nx[ABITS-1:0];
  assign arr_addr = (state_q == ST_DATA) ? addr_q : dec_addr;

  ser_eeprom_array #(.ABITS(ABITS)) array_i (
    .clk     (clk),
    .wide_i  (wide_i),
    .addr_i  (arr_addr),
    .op_i    (mem_op),
    .wdata_i (mem_wd),
    .rdata_o (rdata)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    hdr_d     = hdr_q;
    dat_d     = dat_q;
    rd_d      = rd_q;
    addr_d    = addr_q;
    prog_en_d = prog_en_q;
    sdo_d     = sdo_q;
    all_d     = all_q;
    busy_d    = busy_q;
    bcnt_d    = bcnt_q;
    mem_op    = MOP_NONE;
    mem_wd    = wide_i ? dat_nx : {8'h00, dat_nx[7:0]};

    if (busy_q) begin
      bcnt_d = bcnt_q - CW'(1);
      if (bcnt_q == CW'(1)) busy_d = 1'b0;
    end

    unique case (state_q)
      ST_IDLE: if (cs_rise) state_d = busy_q ? ST_STAT : ST_WAIT;
      ST_WAIT: if (sk_rise && di_s) begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR: if (sk_rise) begin
        hdr_d = hdr_nx[HBITS-2:0];
        cnt_d = cnt_q + BW'(1);
        if (cnt_q == (wide_i ? HLAST_W : HLAST_N)) begin
          addr_d  = dec_addr;
          cnt_d   = '0;
          state_d = ST_HOLD;
          unique case (opc)
            2'b10: begin
              state_d = ST_READ;
              sdo_d   = 1'b0;
              rd_d    = wide_i ? rdata : {rdata[7:0], 8'h00};
            end
            2'b01: begin
              state_d = ST_DATA;
              all_d   = 1'b0;
            end
            2'b11: if (prog_en_q) begin
              mem_op = MOP_WORD;
              mem_wd = '1;
            end
            default: unique case (sub)
              2'b11: prog_en_d = 1'b1;
              2'b00: prog_en_d = 1'b0;
              2'b10: if (prog_en_q) begin
                mem_op = MOP_ALL;
                mem_wd = '1;
              end
              default: begin
                state_d = ST_DATA;
                all_d   = 1'b1;
              end
            endcase
          endcase
        end
      end
      ST_DATA: if (sk_rise) begin
        dat_d = dat_nx[14:0];
        cnt_d = cnt_q + BW'(1);
        if (cnt_q == (wide_i ? DLAST_W : DLAST_N)) begin
          state_d = ST_HOLD;
          if (prog_en_q) mem_op = all_q ? MOP_ALL : MOP_WORD;
        end
      end
      ST_READ: if (sk_rise) begin
        sdo_d = rd_q[15];
        rd_d  = {rd_q[14:0], 1'b0};
      end
      default: ;
    endcase

    if (mem_op != MOP_NONE) begin
      busy_d = 1'b1;
      bcnt_d = CW'(PROG_CYCLES);
    end
    if (!cs_s) state_d = ST_IDLE;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      dat_q     <= '0;
      rd_q      <= '0;
      addr_q    <= '0;
      bcnt_q    <= '0;
      prog_en_q <= 1'b0;
      busy_q    <= 1'b0;
      sdo_q     <= 1'b0;
      all_q     <= 1'b0;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      hdr_q     <= hdr_d;
      dat_q     <= dat_d;
      rd_q      <= rd_d;
      addr_q    <= addr_d;
      bcnt_q    <= bcnt_d;
      prog_en_q <= prog_en_d;
      busy_q    <= busy_d;
      sdo_q     <= sdo_d;
      all_q     <= all_d;
      cs_q      <= cs_s;
      sk_q      <= sk_s;
    end
  end

  assign sdo_oe_o = (state_q == ST_READ) || (state_q == ST_STAT);
  assign sdo_o    = (state_q == ST_STAT) ? ~busy_q : sdo_q;

  p_hiz_after_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdo_oe_o);
  p_prog_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_op != MOP_NONE) |-> prog_en_q);
  p_prog_starts_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_op != MOP_NONE) |=> busy_q);
  p_no_prog_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (mem_op == MOP_NONE));
endmodule

// File: tb/ser_eeprom_slave_tb.sv
module ser_eeprom_slave_tb_top;
  localparam int PROG = 1000;
  localparam int HALF = 8;

  typedef struct packed {
    logic        w;
    logic [6:0]  a;
    logic [15:0] d;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 7'd0,   16'h00A5},
    '{1'b0, 7'd127, 16'h003C},
    '{1'b1, 7'd63,  16'hBEEF},
    '{1'b1, 7'd0,   16'h1234},
    '{1'b0, 7'd64,  16'h0081}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, wide = 1'b0;
  logic sdo, sdo_oe;
  int   nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  ser_eeprom_slave #(.ABITS(7), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .wide_i(wide), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sk_bit(logic b);
    sdi = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic cs_on;  sel = 1'b1; tick(HALF); endtask
  task automatic cs_off; sdi = 1'b0; sel = 1'b0; tick(HALF); endtask

  task automatic send_hdr(logic w, logic [1:0] op, int a);
    int aw = w ? 6 : 7;
    sk_bit(1'b1); sk_bit(op[1]); sk_bit(op[0]);
    for (int i = aw - 1; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_data(logic w, logic [15:0] d);
    for (int i = (w ? 15 : 7); i >= 0; i--) sk_bit(d[i]);
  endtask

  task automatic do_write(logic w, int a, logic [15:0] d);
    wide = w; cs_on; send_hdr(w, 2'b01, a); send_data(w, d); cs_off;
  endtask

  task automatic do_special(logic w, logic [1:0] sub, logic [15:0] d, logic has_data);
    wide = w; cs_on; send_hdr(w, 2'b00, int'(sub) << (w ? 4 : 5));
    if (has_data) send_data(w, d);
    cs_off;
  endtask

  task automatic do_erase(logic w, int a);
    wide = w; cs_on; send_hdr(w, 2'b11, a); cs_off;
  endtask

  task automatic do_read(logic w, int a, int lead, output logic [15:0] got);
    wide = w; got = '0; cs_on;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    send_hdr(w, 2'b10, a);
    check("R3 dummy bit", {14'h0, sdo_oe, sdo}, 16'h0002);
    for (int i = 0; i < (w ? 16 : 8); i++) begin
      sk_bit(1'b0);
      got = {got[14:0], sdo};
    end
    cs_off;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R7 actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] got;
    tick(5); rst_n = 1'b1; tick(5);
    check("R9 oe after reset", {15'h0, sdo_oe}, 16'h0000);

    // R4: reset returns the latch to disabled
    do_special(1'b0, 2'b11, 16'h0, 1'b0);
    do_write(1'b0, 9, 16'h0077); tick(PROG + 40);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5);
    do_write(1'b0, 9, 16'h0011); tick(PROG + 40);
    do_read(1'b0, 9, 0, got); check("R4 write ignored after reset", got, 16'h0077);

    // R5/R2/R3: table of writes and read-backs
    do_special(1'b0, 2'b11, 16'h0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      do_write(VECS[i].w, int'(VECS[i].a), VECS[i].d); tick(PROG + 40);
      do_read(VECS[i].w, int'(VECS[i].a), 0, got);
      check("R5 table read-back", got, VECS[i].d);
    end

    // R1: leading zeros before start bit
    do_read(1'b0, 64, 3, got); check("R1 leading zeros", got, 16'h0081);

    // R2: wide word maps onto an aligned byte pair
    do_write(1'b1, 3, 16'hC33C); tick(PROG + 40);
    do_read(1'b0, 6, 0, got); check("R2 upper byte", got, 16'h00C3);
    do_read(1'b0, 7, 0, got); check("R2 lower byte", got, 16'h003C);

    // R5: erase
    do_write(1'b0, 10, 16'h0055); tick(PROG + 40);
    do_erase(1'b0, 10); tick(PROG + 40);
    do_read(1'b0, 10, 0, got); check("R5 erase byte", got, 16'h00FF);
    do_erase(1'b1, 20); tick(PROG + 40);
    do_read(1'b1, 20, 0, got); check("R5 erase word", got, 16'hFFFF);

    // R8/R7: status polling and instruction rejected while busy
    do_write(1'b0, 30, 16'h0042);
    cs_on; check("R8 busy status", {14'h0, sdo_oe, sdo}, 16'h0002);
    cs_off; cs_on;
    send_hdr(1'b0, 2'b01, 30); send_data(1'b0, 16'h0099);
    tick(PROG + 40);
    check("R8 ready status", {14'h0, sdo_oe, sdo}, 16'h0003);
    cs_off; check("R9 oe after deselect", {15'h0, sdo_oe}, 16'h0000);
    cs_on; check("R8 no status after cycle", {15'h0, sdo_oe}, 16'h0000);
    cs_off;
    do_read(1'b0, 30, 0, got); check("R7 write during busy ignored", got, 16'h0042);

    // R7: busy window length
    do_write(1'b0, 31, 16'h0024);
    tick(PROG - 100);
    cs_on; check("R7 still busy near end", {14'h0, sdo_oe, sdo}, 16'h0002);
    cs_off; tick(200);
    cs_on; check("R7 idle after window", {15'h0, sdo_oe}, 16'h0000);
    cs_off;

    // R4: disable blocks changes, read still works
    do_special(1'b0, 2'b00, 16'h0, 1'b0);
    do_write(1'b0, 0, 16'h00EE); tick(PROG + 40);
    do_erase(1'b0, 0); tick(PROG + 40);
    do_read(1'b0, 0, 0, got); check("R4 disabled ignores change", got, 16'h0012);

    // R6: erase all and write all
    do_special(1'b0, 2'b11, 16'h0, 1'b0);
    do_special(1'b0, 2'b10, 16'h0, 1'b0); tick(PROG + 40);
    do_read(1'b0, 127, 0, got); check("R6 erase all byte", got, 16'h00FF);
    do_read(1'b1, 5, 0, got);   check("R6 erase all word", got, 16'hFFFF);
    do_special(1'b0, 2'b01, 16'h005A, 1'b1); tick(PROG + 40);
    do_read(1'b0, 100, 0, got); check("R6 write all byte", got, 16'h005A);
    do_read(1'b1, 7, 0, got);   check("R6 write all pair", got, 16'h5A5A);
    do_special(1'b1, 2'b01, 16'h1357, 1'b1); tick(PROG + 40);
    do_read(1'b1, 2, 0, got);   check("R6 write all word", got, 16'h1357);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule